// File: doc/BRIEF.md
# Translation Fault Recorder

This block sits beside an address translator and keeps a record of the translation faults it reports. It holds a fault status word and the page address of the latest fault. Software reads both through a small read port, and reading the status word empties it. If a second fault arrives before software has read the first, the block flags an overflow.

For every fault, the block also chooses one of two responses. It either asks the core to trap, or it quietly grants the access with full permissions on a 4 KB page. A trap is typed as an instruction fault or a data fault, depending on the kind of access that failed. The quiet grant is chosen when the no-fault control bit is set or when traps are disabled.

The response logic is a four-state machine:
- `RS_IDLE`: nothing pending.
- `RS_TRAP_I`: instruction-fault trap.
- `RS_TRAP_D`: data-fault trap.
- `RS_GRANT`: override grant.

Every state moves on each clock edge:
- A fault with the no-fault bit set, or with traps disabled, takes the transition *to_grant* into `RS_GRANT`.
- Any other fault takes *to_trap_i* into `RS_TRAP_I` when access index bit 1 (fetch) is set, and *to_trap_d* into `RS_TRAP_D` when it is not.
- A cycle with no fault takes *to_idle* back to `RS_IDLE`.

Because every state leaves after one cycle, each response is a single-cycle pulse.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset the status word and the address register are zero, and `trap_req`, `ovr_grant` and `rd_valid` are low.
- R2: A fault on an empty status word stores the following fields, and the word reads back with exactly these bits:
  - bits [9:8]: `flt_level`
  - bits [7:5]: `flt_acc`
  - bits [4:2]: `flt_type`
  - bit 1: set, marking the address as valid
  - bit 0: clear
- R3: A fault that arrives while the status word is nonzero, and is not being read that cycle, first discards the old fields while keeping bit 0 set as overflow. It then merges in the new fields as in R2.
- R4: On every fault the address register takes `flt_addr` with its low 12 bits forced to zero.
- R5: A read with `rd_sel`=0 returns the status word and a read with `rd_sel`=1 returns the address. Each is returned on `rd_data` with `rd_valid` high one cycle after `rd_en`. A status read clears the status word; an address read changes nothing.
- R6: A status read and a fault in the same cycle return the old status word, and leave the new fault's fields with bit 0 clear.
- R7: A fault with `nofault_mode`=1 or `trap_en`=0 produces no trap. It produces a one-cycle `ovr_grant` in the next cycle, with `ovr_perm`=3'b111 (read, write, execute).
- R8: A fault with `trap_en`=1 and `nofault_mode`=0 produces a one-cycle `trap_req` in the next cycle. `trap_type` is 2'b01 (instruction) when `flt_acc` bit 1 is set and 2'b10 (data) otherwise.
- R9: Cycles without `flt_valid` change neither register and raise neither `trap_req` nor `ovr_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault report pulse from the translator |
| flt_type | input | 3 | Fault type code |
| flt_level | input | 2 | Table level at which the walk stopped |
| flt_acc | input | 3 | Access index: bit2 write, bit1 fetch, bit0 supervisor |
| flt_addr | input | 32 | Faulting virtual address |
| nofault_mode | input | 1 | No-fault control bit |
| trap_en | input | 1 | Traps enabled |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = status word, 1 = address register |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| trap_req | output | 1 | Trap request pulse |
| trap_type | output | 2 | 01 instruction fault, 10 data fault |
| ovr_grant | output | 1 | Override grant pulse |
| ovr_perm | output | 3 | Granted permissions {read, write, execute} |

## Verification
The status read-and-clear and the capture of a new fault can land in the same clock edge, and the block must resolve them in favour of the new fault without flagging overflow. The bench provokes this by raising `rd_en` with `rd_sel`=0 in the same cycle as `flt_valid`, while an earlier fault is still stored. It then judges the outcome twice: the returned word must equal the old fault's status, and a later status read must show only the new fault's fields with bit 0 clear.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    localparam int TYPE_W    = 3;
    localparam int LVL_W     = 2;
    localparam int ACC_W     = 3;
    localparam int STAT_W    = LVL_W + ACC_W + TYPE_W + 2;
    localparam int ACC_FETCH = 1;

    localparam logic RSEL_STATUS = 1'b0;
    localparam logic RSEL_ADDR   = 1'b1;

    localparam logic [1:0] TT_INST = 2'b01;
    localparam logic [1:0] TT_DATA = 2'b10;
    localparam logic [2:0] PERM_ALL = 3'b111;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_TRAP_I = 2'd1,
        RS_TRAP_D = 2'd2,
        RS_GRANT  = 2'd3
    } resp_state_e;
endpackage

// File: rtl/mfs_status_regs.sv
module mfs_status_regs
    import mfs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flt_valid,
    input  logic [TYPE_W-1:0]    flt_type,
    input  logic [LVL_W-1:0]     flt_level,
    input  logic [ACC_W-1:0]     flt_acc,
    input  logic [ADDR_W-1:0]    flt_addr,
    input  logic                 rd_en,
    input  logic                 rd_sel,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [STAT_W-1:0]    stat_out
);
    logic [STAT_W-1:0] stat_q;
    logic [ADDR_W-1:0] far_q;
    logic [STAT_W-1:0] new_bits;
    logic [STAT_W-1:0] keep_bits;
    logic              stat_clr;

    always_comb begin
        stat_clr  = rd_en && (rd_sel == RSEL_STATUS);
        new_bits  = {flt_level, flt_acc, flt_type, 1'b1, 1'b0};
        keep_bits = (stat_clr || (stat_q == '0)) ? '0 : STAT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            far_q  <= '0;
        end else begin
            if (flt_valid) begin
                stat_q <= keep_bits | new_bits;
                far_q  <= {flt_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
            end else if (stat_clr) begin
                stat_q <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= (rd_sel == RSEL_ADDR) ? DATA_W'(far_q) : DATA_W'(stat_q);
            end
        end
    end

    assign stat_out = stat_q;
endmodule

// File: rtl/mfs_resp_fsm.sv
module mfs_resp_fsm
    import mfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_valid,
    input  logic       flt_fetch,
    input  logic       nofault_mode,
    input  logic       trap_en,
    output logic       trap_req,
    output logic [1:0] trap_type,
    output logic       ovr_grant,
    output logic [2:0] ovr_perm
);
    resp_state_e state_q, state_d;

    always_comb begin
        state_d = RS_IDLE;
        if (flt_valid) begin
            if (nofault_mode || !trap_en) state_d = RS_GRANT;
            else if (flt_fetch)           state_d = RS_TRAP_I;
            else                          state_d = RS_TRAP_D;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        trap_req  = 1'b0;
        trap_type = 2'b00;
        ovr_grant = 1'b0;
        ovr_perm  = 3'b000;
        unique case (state_q)
            RS_IDLE:   ;
            RS_TRAP_I: begin trap_req = 1'b1; trap_type = TT_INST; end
            RS_TRAP_D: begin trap_req = 1'b1; trap_type = TT_DATA; end
            RS_GRANT:  begin ovr_grant = 1'b1; ovr_perm = PERM_ALL; end
        endcase
    end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
    import mfs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [2:0]        flt_type,
    input  logic [1:0]        flt_level,
    input  logic [2:0]        flt_acc,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              nofault_mode,
    input  logic              trap_en,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              trap_req,
    output logic [1:0]        trap_type,
    output logic              ovr_grant,
    output logic [2:0]        ovr_perm
);
    logic [STAT_W-1:0] status_now;

    mfs_status_regs #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_type(flt_type),
        .flt_level(flt_level), .flt_acc(flt_acc), .flt_addr(flt_addr),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
        .stat_out(status_now)
    );

    mfs_resp_fsm i_resp (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid),
        .flt_fetch(flt_acc[ACC_FETCH]), .nofault_mode(nofault_mode),
        .trap_en(trap_en), .trap_req(trap_req), .trap_type(trap_type),
        .ovr_grant(ovr_grant), .ovr_perm(ovr_perm)
    );
endmodule

// File: rtl/mfs_chk.sv
module mfs_chk
    import mfs_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic [2:0]        flt_acc,
    input logic              nofault_mode,
    input logic              trap_en,
    input logic              rd_en,
    input logic              rd_sel,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              trap_req,
    input logic [1:0]        trap_type,
    input logic              ovr_grant,
    input logic [2:0]        ovr_perm,
    input logic [STAT_W-1:0] stat_q
);
    AST_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> stat_q[1]); // R2
    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && stat_q != '0 && !(rd_en && rd_sel == RSEL_STATUS)) |=> stat_q[0]); // R3
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_sel) == RSEL_ADDR) |-> rd_data[PAGE_BITS-1:0] == '0); // R4
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == RSEL_STATUS && !flt_valid) |=> stat_q == '0); // R5
    AST_NO_OVERFLOW_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == RSEL_STATUS && flt_valid) |=> !stat_q[0]); // R6
    AST_GRANT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_grant |-> ($past(flt_valid && (nofault_mode || !trap_en)) && ovr_perm == PERM_ALL)); // R7
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && ovr_grant)); // R7
    AST_TRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(flt_valid && trap_en && !nofault_mode)); // R8
    AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_type == ($past(flt_acc[ACC_FETCH]) ? TT_INST : TT_DATA)); // R8
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> (!trap_req && !ovr_grant)); // R9
endmodule

bind mmu_fault_capture mfs_chk #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_acc(flt_acc),
    .nofault_mode(nofault_mode), .trap_en(trap_en), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .trap_req(trap_req), .trap_type(trap_type),
    .ovr_grant(ovr_grant), .ovr_perm(ovr_perm), .stat_q(status_now)
);

// File: tb/test_mmu_fault_capture.sv
module test_mmu_fault_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [1:0]  flt_level = '0;
    logic [2:0]  flt_acc = '0;
    logic [31:0] flt_addr = '0;
    logic        nofault_mode = 1'b0;
    logic        trap_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        trap_req;
    logic [1:0]  trap_type;
    logic        ovr_grant;
    logic [2:0]  ovr_perm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_stat = '0;
    logic [31:0] m_addr = '0;

    int          rsp_q[$];
    string       rsp_tag[$];
    logic [31:0] rd_q[$];
    string       rd_tag[$];

    always #10 clk = ~clk;

    mmu_fault_capture i_mmu_fault_capture (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_type(flt_type),
        .flt_level(flt_level), .flt_acc(flt_acc), .flt_addr(flt_addr),
        .nofault_mode(nofault_mode), .trap_en(trap_en), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_valid(rd_valid), .rd_data(rd_data), .trap_req(trap_req), .trap_type(trap_type),
        .ovr_grant(ovr_grant), .ovr_perm(ovr_perm)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; the model follows the requirements
    task automatic step(input bit fv, input logic [2:0] ty, input logic [1:0] lv,
                        input logic [2:0] ac, input logic [31:0] ad, input bit nf,
                        input bit te, input bit re, input bit sel, input string tag);
        logic [31:0] nb;
        flt_valid = fv; flt_type = ty; flt_level = lv; flt_acc = ac; flt_addr = ad;
        nofault_mode = nf; trap_en = te; rd_en = re; rd_sel = sel;
        if (re) begin
            rd_q.push_back(sel ? m_addr : m_stat);
            rd_tag.push_back(tag);
        end
        if (fv) begin
            nb = {22'd0, lv, ac, ty, 2'b10};
            if (re && !sel)            m_stat = nb;          // R6
            else if (m_stat != 0)      m_stat = 32'd1 | nb;  // R3
            else                       m_stat = nb;          // R2
            m_addr = ad & 32'hFFFF_F000;                     // R4
            if (nf || !te)             rsp_q.push_back(3);   // R7
            else if (ac[1])            rsp_q.push_back(1);   // R8
            else                       rsp_q.push_back(2);
            rsp_tag.push_back(tag);
        end else if (re && !sel) begin
            m_stat = 0;                                      // R5
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    endtask

    task automatic rd(input bit sel, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, sel, tag);
    endtask

    // monitor: pop and compare whenever the design produces a result
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (trap_req || ovr_grant) begin
                int obs;
                obs = ovr_grant ? ((ovr_perm == 3'b111 && !trap_req) ? 3 : 0)
                                : (trap_type == 2'b01 ? 1 : (trap_type == 2'b10 ? 2 : 0));
                if (rsp_q.size() == 0) check(0, "R9 unexpected response", 32'(obs), 0);
                else begin
                    int e;
                    string t;
                    e = rsp_q.pop_front();
                    t = rsp_tag.pop_front();
                    check(obs == e, t, 32'(obs), 32'(e));
                end
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) check(0, "R5 unexpected read", rd_data, 0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = rd_tag.pop_front();
                    check(rd_data === e, t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!trap_req && !ovr_grant && !rd_valid, "R1 outputs after reset",
              {29'd0, trap_req, ovr_grant, rd_valid}, 0);
        rd(0, "R1 status zero");
        rd(1, "R1 address zero");
        idle(2);
        // R2/R8 data fault, supervisor load
        step(1, 3'd1, 2'd0, 3'b001, 32'h1234_5ABC, 0, 1, 0, 0, "R8 data trap");
        idle(1);
        rd(1, "R4 aligned address");
        rd(0, "R2 status fields");
        rd(0, "R5 cleared after read");
        // R8 instruction fault
        step(1, 3'd4, 2'd2, 3'b011, 32'hDEAD_BFFF, 0, 1, 0, 0, "R8 instruction trap");
        idle(1);
        rd(0, "R2 status fetch fault");
        // R3 overflow
        step(1, 3'd2, 2'd1, 3'b101, 32'h0000_1FFF, 0, 1, 0, 0, "R8 first of pair");
        step(1, 3'd1, 2'd3, 3'b000, 32'hFFFF_0123, 0, 1, 0, 0, "R8 second back-to-back");
        idle(1);
        rd(0, "R3 overflow status");
        // R7 override
        step(1, 3'd4, 2'd0, 3'b110, 32'h4000_0800, 1, 1, 0, 0, "R7 grant no-fault bit");
        idle(1);
        step(1, 3'd1, 2'd1, 3'b010, 32'h8000_0000, 0, 0, 0, 0, "R7 grant traps off");
        idle(1);
        rd(0, "R3 overflow after grants");
        // R6 read and fault in the same cycle
        step(1, 3'd1, 2'd0, 3'b001, 32'h0101_0101, 0, 1, 0, 0, "R8 setup");
        step(1, 3'd4, 2'd1, 3'b100, 32'h0202_0202, 0, 1, 1, 0, "R6 read returns old word");
        idle(1);
        rd(0, "R6 new fault without overflow");
        // R5 address read does not clear; R9 quiet cycles
        step(1, 3'd2, 2'd2, 3'b111, 32'h7654_3210, 1, 0, 0, 0, "R7 grant");
        rd(1, "R5 address read");
        idle(6);
        rd(1, "R9 address unchanged");
        rd(0, "R9 status unchanged");
        idle(3);
        check(rsp_q.size() == 0, "R9 response queue drained", 32'(rsp_q.size()), 0);
        check(rd_q.size() == 0, "R5 read queue drained", 32'(rd_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule